// File: doc/BRIEF.md
# In-Order Register Pending-Write Scoreboard

This block tracks, for every architectural register of an in-order pipeline, whether an instruction that has already issued will still write that register. Its functional units have different latencies, so results can return in any order. Each cycle the decode stage presents up to two source register indices and one destination register index. Each index has its own enable flag. The block answers at once with a stall when the instruction must wait. It waits for a read-after-write hazard when a source register is still pending. It waits for a write-after-write hazard when its destination register is still pending, because a younger write could otherwise land before an older one.

When the instruction is not stalled it issues. In the same cycle its destination register becomes pending, and the new bit is visible from the next cycle. Functional units report completions on a single writeback port, and each completion clears the pending bit of its register. A completion that arrives in the same cycle as a decode check is bypassed: the register already counts as free for that check. Register 0 is hard-wired as never pending.

Top module: `issue_scoreboard`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears every pending bit, so `pending` reads all zeros in the cycle after reset.
- R2: With `dec_valid` high, an enabled source operand (`src_a_en` or `src_b_en`) whose register is pending makes `stall` high in the same cycle (read-after-write).
- R3: With `dec_valid` high and `dst_en` high, a pending destination register makes `stall` high in the same cycle (write-after-write).
- R4: `issue` equals `dec_valid` and not `stall`. When `issue` is high and `dst_en` is high, bit `dst_idx` of `pending` is set in the following cycle.
- R5: A writeback (`wb_valid` high) clears bit `wb_idx` of `pending` in the following cycle, whatever the order in which writebacks arrive relative to issue.
- R6: An operand field whose enable flag is low never causes a stall, whatever its index and the pending state.
- R7: A register being written back in the current cycle counts as not pending for that cycle's hazard check.
- R8: Register index 0 is never pending (`pending[0]` is always 0) and never causes a stall.
- R9: If an issue sets a register that is being written back in the same cycle, the bit is set in the following cycle (the new write wins over the old clear).
- R10: With `dec_valid` low, `stall` and `issue` are low and no pending bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | An instruction is present at decode |
| src_a_en | input | 1 | First source operand is used |
| src_a_idx | input | 5 | First source register index |
| src_b_en | input | 1 | Second source operand is used |
| src_b_idx | input | 5 | Second source register index |
| dst_en | input | 1 | Instruction writes a destination register |
| dst_idx | input | 5 | Destination register index |
| wb_valid | input | 1 | A completion is reported this cycle |
| wb_idx | input | 5 | Register written by the completing instruction |
| stall | output | 1 | Decode must hold the instruction this cycle |
| issue | output | 1 | Instruction issues this cycle |
| pending | output | 32 | One bit per register, set while a write is outstanding |

## Verification
A wrong pending bit shows at the ports in one of two ways. A bit set by mistake raises `stall` on the first decode that names that register. A bit that was lost lets a dependent instruction issue, and `pending` shows the difference one cycle after the faulty set or clear. The bench keeps a reference bit vector. It compares `stall` and `issue` in the cycle of each decode and `pending` after every clock. Any error in the set, clear, bypass or register-0 logic therefore appears within one cycle of the event that caused it.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_NREG = 32;

    typedef struct packed {
        logic [SB_NREG-1:0] pend;
    } sb_state_t;
endpackage

// File: rtl/sb_index_decode.sv
module sb_index_decode #(
    parameter int NREG  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  mask
);
    // One-hot decode; register 0 never produces a bit.
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        if (g == 0) begin : g_zero
            assign mask[g] = 1'b0;
        end else begin : g_reg
            assign mask[g] = en && (idx == IDX_W'(g));
        end
    end
endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check #(
    parameter int NREG  = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  busy,
    input  logic             dec_valid,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    input  logic             d_en,
    input  logic [IDX_W-1:0] d_idx,
    output logic             stall
);
    logic raw_hit;
    logic waw_hit;

    always_comb begin
        raw_hit = (a_en && busy[a_idx]) || (b_en && busy[b_idx]);
        waw_hit = d_en && busy[d_idx];
        stall   = dec_valid && (raw_hit || waw_hit);
    end
endmodule

// File: rtl/sb_pending_array.sv
module sb_pending_array
    import sb_pkg::*;
#(
    parameter int NREG = SB_NREG
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] set_mask,
    input  logic [NREG-1:0] clr_mask,
    output logic [NREG-1:0] pend_q
);
    typedef struct packed {
        logic [NREG-1:0] pend;
    } arr_state_t;

    arr_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // A new issue overrides a completion to the same register.
        st_d.pend = (st_q.pend & ~clr_mask) | set_mask;
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pend_q = st_q.pend;

    p_zero_never_r8: assert property (@(posedge clk) disable iff (rst)
        !pend_q[0]);

    p_set_over_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((pend_q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG  = SB_NREG,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic             src_a_en,
    input  logic [IDX_W-1:0] src_a_idx,
    input  logic             src_b_en,
    input  logic [IDX_W-1:0] src_b_idx,
    input  logic             dst_en,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             wb_valid,
    input  logic [IDX_W-1:0] wb_idx,
    output logic             stall,
    output logic             issue,
    output logic [NREG-1:0]  pending
);
    logic [NREG-1:0] clr_mask;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] busy_now;
    logic            hz_stall;

    sb_index_decode #(.NREG(NREG)) i_clr_dec (
        .en   (wb_valid),
        .idx  (wb_idx),
        .mask (clr_mask)
    );

    sb_index_decode #(.NREG(NREG)) i_set_dec (
        .en   (issue && dst_en),
        .idx  (dst_idx),
        .mask (set_mask)
    );

    // Writeback bypass: a register completing now is already free.
    assign busy_now = pending & ~clr_mask;

    sb_hazard_check #(.NREG(NREG)) i_hazard (
        .busy      (busy_now),
        .dec_valid (dec_valid),
        .a_en      (src_a_en),
        .a_idx     (src_a_idx),
        .b_en      (src_b_en),
        .b_idx     (src_b_idx),
        .d_en      (dst_en),
        .d_idx     (dst_idx),
        .stall     (hz_stall)
    );

    assign stall = hz_stall;
    assign issue = dec_valid && !hz_stall;

    sb_pending_array #(.NREG(NREG)) i_array (
        .clk      (clk),
        .rst      (rst),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .pend_q   (pending)
    );

    p_raw_stall_r2: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && src_a_en && pending[src_a_idx] && !(wb_valid && wb_idx == src_a_idx))
        |-> stall);

    p_waw_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dst_en && pending[dst_idx] && !(wb_valid && wb_idx == dst_idx))
        |-> stall);

    p_issue_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && dst_en && dst_idx != '0) |=> pending[$past(dst_idx)]);

    p_wb_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !(issue && dst_en && dst_idx == wb_idx)) |=> !pending[$past(wb_idx)]);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!stall && !issue));
endmodule

// File: tb/test_issue_scoreboard.sv
module test_issue_scoreboard;
    localparam int NREG = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic        dec_valid, src_a_en, src_b_en, dst_en, wb_valid;
    logic [4:0]  src_a_idx, src_b_idx, dst_idx, wb_idx;
    logic        stall, issue;
    logic [31:0] pending;

    logic [31:0] model;
    int          n_vec = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    issue_scoreboard i_issue_scoreboard (
        .clk(clk), .rst(rst), .dec_valid(dec_valid),
        .src_a_en(src_a_en), .src_a_idx(src_a_idx),
        .src_b_en(src_b_en), .src_b_idx(src_b_idx),
        .dst_en(dst_en), .dst_idx(dst_idx),
        .wb_valid(wb_valid), .wb_idx(wb_idx),
        .stall(stall), .issue(issue), .pending(pending)
    );

    task automatic check1(input string req, input logic act, input logic exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check stall/issue before the
    // rising edge and the pending vector after it.
    task automatic apply(input string req,
                         input logic dv,
                         input logic ae, input logic [4:0] ai,
                         input logic be, input logic [4:0] bi,
                         input logic de, input logic [4:0] di,
                         input logic wv, input logic [4:0] wi);
        logic [31:0] eff;
        logic        exp_stall, exp_issue;
        dec_valid = dv; src_a_en = ae; src_a_idx = ai; src_b_en = be; src_b_idx = bi;
        dst_en = de; dst_idx = di; wb_valid = wv; wb_idx = wi;
        eff = model & ~(wv ? (32'd1 << wi) : 32'd0);
        eff[0] = 1'b0;
        exp_stall = dv && ((ae && eff[ai]) || (be && eff[bi]) || (de && eff[di]));
        exp_issue = dv && !exp_stall;
        #1;
        check1({req, " stall"}, stall, exp_stall);
        check1({req, " issue"}, issue, exp_issue);
        @(posedge clk);
        model = model & ~(wv ? (32'd1 << wi) : 32'd0);
        if (exp_issue && de && di != 5'd0) model = model | (32'd1 << di);
        model[0] = 1'b0;
        @(negedge clk);
        n_vec++;
        if (pending !== model) begin
            n_bad++;
            $display("FAIL %s pending: got %h expected %h", req, pending, model);
        end
    endtask

    task automatic idle();
        apply("R10", 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
    endtask

    initial begin
        logic [31:0] seed;
        rst = 1'b1; dec_valid = 1'b0; src_a_en = 1'b0; src_b_en = 1'b0; dst_en = 1'b0;
        wb_valid = 1'b0; src_a_idx = '0; src_b_idx = '0; dst_idx = '0; wb_idx = '0;
        model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        n_vec++;
        if (pending !== 32'd0) begin
            n_bad++;
            $display("FAIL R1: got %h expected 0", pending);
        end

        // R4/R8: issue a write to every register, including register 0
        for (int r = 0; r < NREG; r++)
            apply(r == 0 ? "R8" : "R4", 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'(r), 1'b0, 5'd0);

        // R2/R3/R6/R8/R10 sweep over every register while all are pending
        for (int r = 0; r < NREG; r++) begin
            apply(r == 0 ? "R8" : "R2", 1'b1, 1'b1, 5'(r), 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
            apply(r == 0 ? "R8" : "R2", 1'b1, 1'b0, 5'd0, 1'b1, 5'(r), 1'b0, 5'd0, 1'b0, 5'd0);
            apply(r == 0 ? "R8" : "R3", 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'(r), 1'b0, 5'd0);
            apply("R6", 1'b1, 1'b0, 5'(r), 1'b0, 5'(r), 1'b0, 5'(r), 1'b0, 5'd0);
            apply("R10", 1'b0, 1'b1, 5'(r), 1'b1, 5'(r), 1'b1, 5'(r), 1'b0, 5'd0);
        end

        // R5/R7: completions in scrambled order, each bypassed to a reader
        for (int k = 0; k < NREG; k++) begin
            logic [4:0] w;
            w = 5'((k * 7 + 3) % NREG);
            apply("R7", 1'b1, 1'b1, w, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, w);
            apply("R5", 1'b1, 1'b1, w, 1'b1, w, 1'b0, 5'd0, 1'b0, 5'd0);
        end

        // R9: issue to a register while its older write completes
        apply("R4", 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 1'b0, 5'd0);
        apply("R9", 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 1'b1, 5'd5);
        apply("R9", 1'b1, 1'b1, 5'd5, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
        apply("R5", 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5);
        idle();

        // Mixed traffic on a small register window to force collisions
        seed = 32'h1234_5678;
        for (int t = 0; t < 3000; t++) begin
            logic [31:0] v;
            seed = seed * 32'd1664525 + 32'd1013904223;
            v = seed;
            apply("R2", v[0] | v[1], v[2], {2'b0, v[5:3]}, v[6], {2'b0, v[9:7]},
                  v[10] | v[11], {2'b0, v[14:12]}, v[15], {2'b0, v[18:16]});
        end

        // R1: reset mid-run clears everything
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        n_vec++;
        if (pending !== 32'd0) begin
            n_bad++;
            $display("FAIL R1: got %h expected 0", pending);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule